// File: doc/BRIEF.md
# Rotating Address Register Generator

This block forms the memory operand address for one instruction of a random-code virtual machine. It takes one selected 64-bit integer register, a second 64-bit register used only as key material, and four 32-bit address registers. The first address register is folded into the selected register with an XOR. The low 32 bits of that result become the raw address. The selected register is then rotated by half its width and returned. The four address registers move one place around their ring.

When the two-bit rekey field is zero, the rotated ring of address registers goes through one AES encryption round. The key for that round is built from the updated selected register and the second register. The raw address is also cut to the width of the memory region chosen by a three-bit location code, and scratchpad addresses are aligned to 8 bytes. The block also reports whether the result goes to a scratchpad address or back to a register.

Each start strobe produces one set of results. The results are registered and appear on the next cycle together with a one-cycle done pulse. The register file around the block supplies the operands and takes the updated values.

Top module: `addr_rotgen`

## Requirements
- R1: While rst_n is low, every output is zero, and done is 0 on the first cycle after reset is released.
- R2: A start sampled high on a clock edge makes done high for exactly the following cycle. Without start, done is 0 and every other output holds its value.
- R3: ra_out equals (ra_in XOR zero-extended g0_in) rotated left by 32 bits, so its upper half is the low 32 bits of that XOR result.
- R4: When gen is 01, 10 or 11, the address registers rotate: g0_out=g1_in, g1_out=g2_in, g2_out=g3_in, g3_out=g0_in.
- R5: rd_addr is the low 32 bits A of ra_in XOR g0_in. Location codes 000 to 011 pass A unchanged. Code 100 gives A[17:0] with bits 2:0 cleared. Codes 101, 110 and 111 give A[13:0] with bits 2:0 cleared. All higher bits are zero.
- R6: Code 000 makes wr_addr equal to A[17:0] with bits 2:0 cleared. Codes 001, 100 and 101 make it A[13:0] with bits 2:0 cleared. For all three, wr_to_reg is 0. Codes 010, 011, 110 and 111 set wr_to_reg to 1 and wr_addr to 0.
- R7: When gen is 00, a 128-bit state is formed from the rotated address registers of R4, with byte i at bits 8i+7:8i. Column c holds bytes 4c to 4c+3, and row r is byte index mod 4. The state goes through SubBytes, then ShiftRows (row r shifted left by r columns), then MixColumns. The result is XORed with the key {ra_out, xb_in}, where ra_out occupies bits 127:64. The result is split back, with g0_out in bits 31:0 and g3_out in bits 127:96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one address generation |
| loc | input | 3 | Location code selecting address widths |
| gen | input | 2 | Rekey field; 00 requests the AES round |
| ra_in | input | 64 | Selected integer register |
| xb_in | input | 64 | Second register, low half of the round key |
| g0_in | input | 32 | Address register 0 |
| g1_in | input | 32 | Address register 1 |
| g2_in | input | 32 | Address register 2 |
| g3_in | input | 32 | Address register 3 |
| rd_addr | output | 32 | Truncated read address |
| wr_addr | output | 32 | Truncated write address, zero when writing to a register |
| wr_to_reg | output | 1 | Result goes to a register instead of the scratchpad |
| ra_out | output | 64 | Updated selected register |
| g0_out | output | 32 | Updated address register 0 |
| g1_out | output | 32 | Updated address register 1 |
| g2_out | output | 32 | Updated address register 2 |
| g3_out | output | 32 | Updated address register 3 |
| done | output | 1 | One-cycle pulse marking valid outputs |

## Verification
The AES round is the hardest part to check from the ports. Its result depends on byte order, on the row shift direction and on whether the key uses the register value before or after rotation, and a random state hides which of these is wrong. The stimulus therefore uses an all-zero state and key, where every byte becomes 0x63. It also mixes all-ones and high-bit patterns into ra_in and g0_in so that the key's upper half differs visibly before and after rotation. A behavioural reference model computes the S-box by brute-force field inversion, and every rekey result is compared with it on every clock.

// File: rtl/addr_rotgen.sv
module addr_rotgen #(
  parameter int RW    = 64,
  parameter int AW    = 32,
  parameter int SP_HI = 18,
  parameter int SP_LO = 14,
  parameter int ALGN  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    loc,
  input  logic [1:0]    gen,
  input  logic [RW-1:0] ra_in,
  input  logic [RW-1:0] xb_in,
  input  logic [AW-1:0] g0_in,
  input  logic [AW-1:0] g1_in,
  input  logic [AW-1:0] g2_in,
  input  logic [AW-1:0] g3_in,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          wr_to_reg,
  output logic [RW-1:0] ra_out,
  output logic [AW-1:0] g0_out,
  output logic [AW-1:0] g1_out,
  output logic [AW-1:0] g2_out,
  output logic [AW-1:0] g3_out,
  output logic          done
);
  localparam int HALF = RW / 2;
  localparam int GW   = 4 * AW;
  localparam logic [AW-1:0] M_HI = AW'((64'd1 << SP_HI) - 1) & ~AW'((1 << ALGN) - 1);
  localparam logic [AW-1:0] M_LO = AW'((64'd1 << SP_LO) - 1) & ~AW'((1 << ALGN) - 1);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xt(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] p, y;
    p = x;
    y = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gf_mul(p, p);
      y = gf_mul(y, p);
    end
    return y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]} ^ {y[3:0], y[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] enc_round(input logic [127:0] s, input logic [127:0] k);
    logic [7:0] sb [16];
    logic [7:0] sh [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) sb[i] = sbox(s[8*i +: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        sh[4*c + r] = sb[4*((c + r) % 4) + r];
    for (int c = 0; c < 4; c++) begin
      o[32*c +: 8]      = xt(sh[4*c]) ^ xt(sh[4*c+1]) ^ sh[4*c+1] ^ sh[4*c+2] ^ sh[4*c+3];
      o[32*c + 8 +: 8]  = sh[4*c] ^ xt(sh[4*c+1]) ^ xt(sh[4*c+2]) ^ sh[4*c+2] ^ sh[4*c+3];
      o[32*c + 16 +: 8] = sh[4*c] ^ sh[4*c+1] ^ xt(sh[4*c+2]) ^ xt(sh[4*c+3]) ^ sh[4*c+3];
      o[32*c + 24 +: 8] = xt(sh[4*c]) ^ sh[4*c] ^ sh[4*c+1] ^ sh[4*c+2] ^ xt(sh[4*c+3]);
    end
    return o ^ k;
  endfunction

  logic [RW-1:0] mixed, rot;
  logic [AW-1:0] raw;
  logic [GW-1:0] g_ring, g_next;
  logic [AW-1:0] rd_n, wr_n;
  logic          reg_n;

  assign mixed  = ra_in ^ {{(RW-AW){1'b0}}, g0_in};
  assign rot    = {mixed[HALF-1:0], mixed[RW-1:HALF]};
  assign raw    = mixed[AW-1:0];
  assign g_ring = {g0_in, g3_in, g2_in, g1_in};
  assign g_next = (gen == 2'b00) ? enc_round(g_ring, {rot, xb_in}) : g_ring;

  always_comb begin
    if (!loc[2])      rd_n = raw;
    else if (loc == 3'b100) rd_n = raw & M_HI;
    else              rd_n = raw & M_LO;
    reg_n = 1'b0;
    wr_n  = '0;
    case (loc)
      3'b000:                 wr_n = raw & M_HI;
      3'b001, 3'b100, 3'b101: wr_n = raw & M_LO;
      default:                reg_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr   <= '0;
      wr_addr   <= '0;
      wr_to_reg <= 1'b0;
      ra_out    <= '0;
      g0_out    <= '0;
      g1_out    <= '0;
      g2_out    <= '0;
      g3_out    <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        rd_addr   <= rd_n;
        wr_addr   <= wr_n;
        wr_to_reg <= reg_n;
        ra_out    <= rot;
        {g3_out, g2_out, g1_out, g0_out} <= g_next;
      end
    end
  end
endmodule

module addr_rotgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  loc,
  input logic [1:0]  gen,
  input logic [63:0] ra_in,
  input logic [31:0] g0_in,
  input logic [31:0] g1_in,
  input logic [31:0] g2_in,
  input logic [31:0] g3_in,
  input logic [31:0] rd_addr,
  input logic [31:0] wr_addr,
  input logic        wr_to_reg,
  input logic [63:0] ra_out,
  input logic [31:0] g0_out,
  input logic [31:0] g3_out,
  input logic        done
);
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(rd_addr) && $stable(ra_out) && $stable(g0_out));
  a_r3_rotated_half: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ra_out[63:32] == ($past(ra_in[31:0]) ^ $past(g0_in)) && ra_out[31:0] == $past(ra_in[63:32]));
  a_r4_ring_shift: assert property (@(posedge clk) disable iff (!rst_n)
    start && gen != 2'b00 |=> g0_out == $past(g1_in) && g3_out == $past(g0_in));
  a_r5_scratch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    start && loc[2] |=> rd_addr[2:0] == 3'b000 && rd_addr[31:18] == 14'd0);
  a_r6_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    start && loc[1] |=> wr_to_reg && wr_addr == 32'd0);
  a_r6_scratch_target: assert property (@(posedge clk) disable iff (!rst_n)
    start && !loc[1] |=> !wr_to_reg && wr_addr[2:0] == 3'b000);
endmodule

bind addr_rotgen addr_rotgen_chk u_chk (.*);

// File: tb/tb_addr_rotgen.sv
module tb_addr_rotgen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  loc = '0;
  logic [1:0]  gen = '0;
  logic [63:0] ra_in = '0, xb_in = '0;
  logic [31:0] g0_in = '0, g1_in = '0, g2_in = '0, g3_in = '0;
  logic [31:0] rd_addr, wr_addr, g0_out, g1_out, g2_out, g3_out;
  logic [63:0] ra_out;
  logic        wr_to_reg, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit running = 0;

  addr_rotgen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int bit_i = 15; bit_i >= 8; bit_i--) if (p[bit_i]) p = p ^ (16'h11b << (bit_i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv, o;
    inv = 8'h00;
    for (int j = 1; j < 256; j++) if (fmul(x, 8'(j)) == 8'h01) inv = 8'(j);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
    return o;
  endfunction

  function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k);
    logic [7:0] st [4][4];
    logic [7:0] sh [4][4];
    logic [7:0] acc, coef;
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) st[r][c] = ref_sbox(s[8*(4*c+r) +: 8]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) sh[r][c] = st[r][(c+r)%4];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        acc = 8'h00;
        for (int j = 0; j < 4; j++) begin
          coef = ((j - r + 4) % 4 == 0) ? 8'h02 : (((j - r + 4) % 4 == 1) ? 8'h03 : 8'h01);
          acc = acc ^ fmul(coef, sh[j][c]);
        end
        o[8*(4*c+r) +: 8] = acc;
      end
    return o ^ k;
  endfunction

  logic [31:0]  e_rd, e_wr, e_g0, e_g1, e_g2, e_g3;
  logic [63:0]  e_ra;
  logic         e_reg, e_done;

  always @(posedge clk) begin
    logic [63:0]  m, rt;
    logic [31:0]  a, rg0, rg1, rg2, rg3;
    logic [127:0] gg;
    if (!rst_n) begin
      e_rd <= 0; e_wr <= 0; e_reg <= 0; e_ra <= 0;
      e_g0 <= 0; e_g1 <= 0; e_g2 <= 0; e_g3 <= 0; e_done <= 0;
    end else begin
      e_done <= start;
      if (start) begin
        m  = ra_in ^ {32'd0, g0_in};
        a  = m[31:0];
        rt = (m << 32) | (m >> 32);
        rg0 = g1_in; rg1 = g2_in; rg2 = g3_in; rg3 = g0_in;
        if (gen == 2'b00) begin
          gg = ref_round({rg3, rg2, rg1, rg0}, {rt, xb_in});
          rg0 = gg[31:0]; rg1 = gg[63:32]; rg2 = gg[95:64]; rg3 = gg[127:96];
        end
        e_ra <= rt;
        e_g0 <= rg0; e_g1 <= rg1; e_g2 <= rg2; e_g3 <= rg3;
        if (loc < 4)       e_rd <= a;
        else if (loc == 4) e_rd <= a % 32'h40000 / 8 * 8;
        else               e_rd <= a % 32'h4000 / 8 * 8;
        if (loc == 0) begin
          e_wr <= a % 32'h40000 / 8 * 8; e_reg <= 0;
        end else if (loc == 1 || loc == 4 || loc == 5) begin
          e_wr <= a % 32'h4000 / 8 * 8; e_reg <= 0;
        end else begin
          e_wr <= 0; e_reg <= 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2 done", 64'(done), 64'(e_done));
      chk("R3 ra_out", ra_out, e_ra);
      chk("R4/R7 g0_out", 64'(g0_out), 64'(e_g0));
      chk("R4/R7 g1_out", 64'(g1_out), 64'(e_g1));
      chk("R4/R7 g2_out", 64'(g2_out), 64'(e_g2));
      chk("R4/R7 g3_out", 64'(g3_out), 64'(e_g3));
      chk("R5 rd_addr", 64'(rd_addr), 64'(e_rd));
      chk("R6 wr_addr", 64'(wr_addr), 64'(e_wr));
      chk("R6 wr_to_reg", 64'(wr_to_reg), 64'(e_reg));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input bit s, input logic [2:0] l, input logic [1:0] g,
                       input logic [63:0] ra, input logic [63:0] xb,
                       input logic [31:0] a0, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [31:0] a3);
    @(negedge clk);
    start = s; loc = l; gen = g; ra_in = ra; xb_in = xb;
    g0_in = a0; g1_in = a1; g2_in = a2; g3_in = a3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", 64'(done), 0);
    chk("R1 reset ra_out", ra_out, 0);
    chk("R1 reset rd_addr", 64'(rd_addr), 0);
    chk("R1 reset g0_out", 64'(g0_out), 0);
    rst_n = 1'b1;
    running = 1;
    // R1: first cycle after reset release
    @(negedge clk);
    chk("R1 done after release", 64'(done), 0);
    // R7: all-zero state and key must give 0x63 in every byte
    drive(1, 3'b010, 2'b00, 64'd0, 64'd0, 32'd0, 32'd0, 32'd0, 32'd0);
    drive(0, 3'b111, 2'b11, 64'hFFFF, 64'h1, 32'h5, 32'h6, 32'h7, 32'h8);
    chk("R7 zero round g0", 64'(g0_out), 64'h63636363);
    chk("R7 zero round g3", 64'(g3_out), 64'h63636363);
    // R2: inputs change without start; outputs must hold
    drive(0, 3'b100, 2'b01, '1, '1, '1, '1, '1, '1);
    drive(0, 3'b000, 2'b00, 64'h1234, 64'h5678, 32'h9, 32'ha, 32'hb, 32'hc);
    // R3/R4/R5/R6: every location code with all-ones and high-bit patterns
    for (int i = 0; i < 16; i++)
      drive(1, 3'(i), 2'(1 + i % 3), (i % 2) ? '1 : 64'h8000_0000_8000_0000,
            64'h0, (i % 3) ? 32'hFFFF_FFFF : 32'h8000_0007, 32'h1111_1111,
            32'h2222_2222, 32'h3333_3333);
    // R7: key from rotated register differs in its upper half
    drive(1, 3'b101, 2'b00, 64'hFFFF_FFFF_0000_0000, 64'h0123_4567_89AB_CDEF,
          32'h8000_0001, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_BABE);
    for (int i = 0; i < 400; i++)
      drive((i % 5) != 4, 3'(i % 8), (i % 3 == 0) ? 2'b00 : 2'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom},
            (i % 7 == 0) ? 32'hFFFF_FFFF : $urandom, $urandom, $urandom, $urandom);
    drive(0, 3'b000, 2'b00, 64'd0, 64'd0, 32'd0, 32'd0, 32'd0, 32'd0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule